// File: doc/BRIEF.md
# PHY Management Register Responder

This block is the register side of a copper PHY's management port, reduced to a parallel request interface. A controller presents a 5-bit register index together with a write strobe and write data, or a read strobe. One clock after a read strobe, the 16-bit answer appears on the read data output.

Most of the 32 locations are plain storage. Four indices return values computed at read time instead of stored contents:

- Basic status (1) reflects the link-up input.
- Partner ability (5) mirrors the local advertisement word, so the synthesized negotiation always agrees with the best advertised mode.
- Speed identification (17) is a fixed gigabit code.
- Diagnostic (18) reports the resolved speed and duplex from the advertisement while the link is up.

No serial framing and no real negotiation exchange take place.

Each read is classified into one of five read kinds, decoded from the index with a unique case:

- KIND_PLAIN returns the stored word.
- KIND_LINK_STAT returns the link-qualified status.
- KIND_PARTNER returns the mirrored advertisement.
- KIND_SPEED_ID returns the constant.
- KIND_DIAG returns the link-qualified speed and duplex.

The only sequential transitions are these:

- Each storage word moves from its reset value to the last written data.
- The read register loads on a read strobe and holds otherwise.

Top module: `phy_mgmt_responder`

## Requirements
- R1: The 5-bit index `req_idx` selects one of 32 registers. A write to a plain register (any index other than 1, 5, 17, 18) is returned unchanged by later reads of that index.
- R2: After reset, these indices read back the following values, and `rd_data` is 0 before the first read:

  | Index | Value |
  |-------|-------|
  | 0 | 0x3100 |
  | 2 | 0x0300 |
  | 3 | 0xE400 |
  | 4 | 0x01E1 |
  | every other plain index | 0x0000 |

- R3: Reading index 1 returns 0x782E (bits 14, 13, 12, 11, 5, 3, 2, 1) while `link_up` is 1, and 0x0000 while `link_up` is 0.
- R4: Reading index 5 returns 0x4000 | (reg4 & 0x01E0) | 0x0001, regardless of the link.
- R5: Reading index 17 always returns 0x8000.
- R6: With `link_up` = 1, reading index 18 returns the following, with all other bits 0:
  - bit 10 = reg4[7] | reg4[8]
  - bit 11 = reg4[8] | reg4[6]

  With `link_up` = 0 it returns 0x0000.
- R7: Writes to indices 1, 5, 17 and 18 are accepted, but reads of those indices keep returning the computed value.
- R8: `rd_data` takes the answer at the clock edge that samples `rd_en` = 1 and holds its value across cycles without a read strobe.
- R9: A read and a write to the same index in the same cycle return the contents from before the write. The new data is visible to the next read.
- R10: A write to index 4 changes the value returned by the next read of index 5 and index 18.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Current link state used by indices 1 and 18 |
| req_idx | input | 5 | Register index for the request |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Registered read answer |

## Verification
The embedded properties watch, on every cycle, the following behaviours:

- Read data holds between strobes.
- Index 17 always answers with the gigabit code.
- Indices 1 and 18 answer zero when the link is down.
- The partner word always carries its fixed flag bits.

Only the bench scenarios can show the behaviours that depend on history:

- The reset contents.
- Storage of plain registers over long random sequences.
- The old-value answer when a read collides with a write.
- Propagation of a new advertisement into the partner and diagnostic answers.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int IDX_W  = 5;
    localparam int DATA_W = 16;

    typedef enum logic [2:0] {
        KIND_PLAIN,
        KIND_LINK_STAT,
        KIND_PARTNER,
        KIND_SPEED_ID,
        KIND_DIAG
    } read_kind_e;

    localparam logic [IDX_W-1:0] IDX_LINK_STAT = 5'd1;
    localparam logic [IDX_W-1:0] IDX_ADV       = 5'd4;
    localparam logic [IDX_W-1:0] IDX_PARTNER   = 5'd5;
    localparam logic [IDX_W-1:0] IDX_SPEED_ID  = 5'd17;
    localparam logic [IDX_W-1:0] IDX_DIAG      = 5'd18;

    localparam logic [DATA_W-1:0] LINK_STAT_UP  = 16'h782E;
    localparam logic [DATA_W-1:0] PARTNER_FIXED = 16'h4001;
    localparam logic [DATA_W-1:0] PARTNER_MASK  = 16'h01E0;
    localparam logic [DATA_W-1:0] SPEED_GIGA    = 16'h8000;

    function automatic read_kind_e kind_of(input logic [IDX_W-1:0] idx);
        read_kind_e k;
        if (idx == IDX_LINK_STAT)      k = KIND_LINK_STAT;
        else if (idx == IDX_PARTNER)   k = KIND_PARTNER;
        else if (idx == IDX_SPEED_ID)  k = KIND_SPEED_ID;
        else if (idx == IDX_DIAG)      k = KIND_DIAG;
        else                           k = KIND_PLAIN;
        return k;
    endfunction

    function automatic logic [DATA_W-1:0] reset_word(input int idx);
        logic [DATA_W-1:0] v;
        case (idx)
            0:       v = 16'h3100;
            2:       v = 16'h0300;
            3:       v = 16'hE400;
            4:       v = 16'h01E1;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
    import phy_mgmt_pkg::*;
#(
    parameter int IW = IDX_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] raw_word,
    output logic [DW-1:0] adv_word
);

    localparam int NREGS = 1 << IW;

    logic [DW-1:0] mem_q [NREGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                mem_q[i] <= reset_word(i);
            end
        end else if (wr_en) begin
            mem_q[idx] <= wr_data;
        end
    end

    always_comb begin
        raw_word = mem_q[idx];
        adv_word = mem_q[IDX_ADV];
    end

endmodule

// File: rtl/phy_mgmt_status.sv
module phy_mgmt_status
    import phy_mgmt_pkg::*;
#(
    parameter int IW = IDX_W,
    parameter int DW = DATA_W
) (
    input  logic [IW-1:0] idx,
    input  logic          link_up,
    input  logic [DW-1:0] raw_word,
    input  logic [DW-1:0] adv_word,
    output logic [DW-1:0] answer
);

    read_kind_e kind;
    logic       fast_mode;
    logic       full_duplex;

    always_comb begin
        kind        = kind_of(idx);
        fast_mode   = adv_word[7] | adv_word[8];
        full_duplex = adv_word[8] | adv_word[6];
        answer      = '0;
        unique case (kind)
            KIND_PLAIN:     answer = raw_word;
            KIND_LINK_STAT: answer = link_up ? LINK_STAT_UP : '0;
            KIND_PARTNER:   answer = PARTNER_FIXED | (adv_word & PARTNER_MASK);
            KIND_SPEED_ID:  answer = SPEED_GIGA;
            KIND_DIAG: begin
                if (link_up) begin
                    answer[10] = fast_mode;
                    answer[11] = full_duplex;
                end
            end
        endcase
    end

endmodule

// File: rtl/phy_mgmt_responder.sv
module phy_mgmt_responder
    import phy_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_up,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] raw_word;
    logic [DATA_W-1:0] adv_word;
    logic [DATA_W-1:0] answer;
    logic [DATA_W-1:0] rd_data_q;

    phy_mgmt_regfile #(.IW(IDX_W), .DW(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .idx      (req_idx),
        .wr_data  (wr_data),
        .raw_word (raw_word),
        .adv_word (adv_word)
    );

    phy_mgmt_status #(.IW(IDX_W), .DW(DATA_W)) u_status (
        .idx      (req_idx),
        .link_up  (link_up),
        .raw_word (raw_word),
        .adv_word (adv_word),
        .answer   (answer)
    );

    // Read register: loads the pre-write answer on a strobe, holds otherwise.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_q <= '0;
        end else if (rd_en) begin
            rd_data_q <= answer;
        end
    end

    assign rd_data = rd_data_q;

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R5
    speed_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && req_idx == IDX_SPEED_ID) |=> (rd_data == 16'h8000));

    // R3
    stat_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && req_idx == IDX_LINK_STAT && !link_up) |=> (rd_data == '0));

    // R6
    diag_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && req_idx == IDX_DIAG && !link_up) |=> (rd_data == '0));

    // R4
    partner_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && req_idx == IDX_PARTNER) |=>
            (rd_data[14] && rd_data[0] && !rd_data[15] && rd_data[4:1] == 4'd0));

endmodule

// File: tb/sim_phy_mgmt_responder.sv
module sim_phy_mgmt_responder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_up = 1'b1;
    logic [4:0]  req_idx = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [15:0] model [32];
    logic [15:0] last_rd = '0;

    always #2.5 clk = ~clk;

    phy_mgmt_responder u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .link_up (link_up),
        .req_idx (req_idx),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data)
    );

    function automatic logic [15:0] expect_read(input logic [4:0] i, input logic lk);
        logic [15:0] a;
        logic [15:0] v;
        a = model[4];
        case (i)
            5'd1:    v = lk ? 16'h782E : 16'h0000;
            5'd5:    v = 16'h4001 | (a & 16'h01E0);
            5'd17:   v = 16'h8000;
            5'd18:   v = lk ? {4'b0, a[8] | a[6], a[7] | a[8], 10'b0} : 16'h0000;
            default: v = model[i];
        endcase
        return v;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One request cycle: drive at negedge, sample just after the capturing edge.
    task automatic op(input string req, input logic [4:0] i, input logic we,
                      input logic [15:0] wd, input logic re, input logic lk);
        logic [15:0] exp;
        @(negedge clk);
        req_idx = i; wr_en = we; wr_data = wd; rd_en = re; link_up = lk;
        exp = re ? expect_read(i, lk) : last_rd;
        @(posedge clk);
        #1;
        check(req, rd_data, exp);
        if (we) model[i] = wd;
        last_rd = rd_data;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = '0;
        model[0] = 16'h3100; model[2] = 16'h0300;
        model[3] = 16'hE400; model[4] = 16'h01E1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R2 reset rd_data", rd_data, 16'h0000);

        // R2 reset contents
        op("R2 idx0", 5'd0, 0, 0, 1, 1);
        op("R2 idx2", 5'd2, 0, 0, 1, 1);
        op("R2 idx3", 5'd3, 0, 0, 1, 1);
        op("R2 idx4", 5'd4, 0, 0, 1, 1);
        op("R2 idx7", 5'd7, 0, 0, 1, 1);
        // R3 link status
        op("R3 up", 5'd1, 0, 0, 1, 1);
        op("R3 down", 5'd1, 0, 0, 1, 0);
        // R4 R5 R6 at reset advertisement
        op("R4 partner", 5'd5, 0, 0, 1, 1);
        op("R5 speed", 5'd17, 0, 0, 1, 0);
        op("R6 diag up", 5'd18, 0, 0, 1, 1);
        op("R6 diag down", 5'd18, 0, 0, 1, 0);
        // R8 hold with no strobe
        op("R8 hold", 5'd3, 1, 16'h5A5A, 0, 1);
        op("R8 hold again", 5'd0, 0, 0, 0, 1);
        // R1 plain storage at top index
        op("R1 write31", 5'd31, 1, 16'hC3A5, 0, 1);
        op("R1 read31", 5'd31, 0, 0, 1, 1);
        // R7 writes to computed indices
        op("R7 wr17", 5'd17, 1, 16'hFFFF, 0, 1);
        op("R7 rd17", 5'd17, 0, 0, 1, 1);
        op("R7 wr1", 5'd1, 1, 16'h0001, 0, 1);
        op("R7 rd1", 5'd1, 0, 0, 1, 1);
        // R9 collision returns old contents
        op("R9 seed", 5'd9, 1, 16'h1234, 0, 1);
        op("R9 collide", 5'd9, 1, 16'hABCD, 1, 1);
        op("R9 after", 5'd9, 0, 0, 1, 1);
        // R10 advertisement drives partner and diagnostic
        op("R10 adv 10full", 5'd4, 1, 16'h0040, 0, 1);
        op("R10 partner", 5'd5, 0, 0, 1, 1);
        op("R10 diag", 5'd18, 0, 0, 1, 1);
        op("R10 adv 100half", 5'd4, 1, 16'h0080, 0, 1);
        op("R10 diag half", 5'd18, 0, 0, 1, 1);
        op("R10 adv none", 5'd4, 1, 16'h0000, 1, 1);
        op("R10 diag none", 5'd18, 0, 0, 1, 1);
        op("R10 partner none", 5'd5, 0, 0, 1, 1);

        // Random mix: R1/R8/R9/R10 and the computed indices
        void'($urandom(32'd1207));
        for (int n = 0; n < 3000; n++) begin
            logic [4:0] i;
            case ($urandom_range(3))
                0: i = 5'd4;
                1: begin
                    case ($urandom_range(3))
                        0: i = 5'd1;
                        1: i = 5'd5;
                        2: i = 5'd17;
                        default: i = 5'd18;
                    endcase
                end
                default: i = 5'($urandom_range(31));
            endcase
            op("R1/R8/R9/R10 random", i, 1'($urandom_range(1)), 16'($urandom),
               1'($urandom_range(1)), 1'($urandom_range(3) != 0));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule